// File: doc/BRIEF.md
# Run-Length Sample Compressor

This block sits between the sampling front end of a logic analyzer and its sample memory. It receives one sample per cycle, qualified by a sample-enable, and writes run-length-encoded words towards memory. Three channel modes are supported: 8, 16 or 32 bits. The mode sets both the width of the stored word and the position of its top bit. That top bit is a flag. Flag clear means the word holds a channel value. Flag set means the word holds how many more times the preceding value was seen. The channel field and the count field are therefore one bit narrower than the mode.

A word is written when the captured channels change and when the repeat counter fills up. Because a full counter is itself a stored event, a wider mode spends far fewer words on idle time: with sparse activity, each count word covers 256 times more samples in 16-bit mode than in 8-bit mode, and 65536 times more again in 32-bit mode. With compression switched off, every enabled sample is stored as a plain value word. All outputs are registered, so a word appears on the port one cycle after the sample edge that causes it.

Top module: `rle_capture_enc`

## Requirements
- R1: While reset is active, and in the first cycle after it, `wr_en` is 0. Reset discards the held value, so the first enabled sample after reset is stored as a value word.
- R2: Channel bits at and above the flag position are cleared before comparison and before storage. In 8-bit mode, a sample of 0x85 equals a held 0x05.
- R3: With compression on, the first enabled sample, or a changed sample while the repeat count is zero, writes the masked value with the flag clear one cycle after the sample.
- R4: With compression on, an enabled sample equal to the held value writes nothing. The only exception is the repeat that fills the counter.
- R5: A changed sample while the repeat count is nonzero writes a count word (flag set, count = number of repeats) one cycle later. The new value word follows in the next cycle.
- R6: When the repeat count reaches all ones in the count field, a count word of all ones with the flag set is written and the count restarts at zero. A following change with the count at zero writes only a value word.
- R7: `chan_mode` 0 selects 8-bit words (flag bit 7, 7-bit field). Mode 1 selects 16-bit words (flag bit 15). Mode 2 or 3 selects 32-bit words (flag bit 31). Bits above the word width read 0.
- R8: With `rle_en` at 0, each enabled sample is written one cycle later as a masked value with the flag clear, and repeats are not compressed. Turning compression on again starts from no held value.
- R9: With no pending value word and `smp_en` at 0, nothing is written in the next cycle.
- R10: If a changed sample arrives in the cycle in which a deferred value word is being written, both value words are written, in arrival order, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | Sample qualifier |
| smp_data | input | 32 | Raw channel sample |
| chan_mode | input | 2 | 0: 8-bit, 1: 16-bit, 2/3: 32-bit |
| rle_en | input | 1 | 1: run-length encoding, 0: plain capture |
| wr_en | output | 1 | Memory write strobe |
| wr_data | output | 32 | Stored word; flag at the top bit of the mode |

## Verification
Two functions can land in the same cycle. The first is the deferred value word left behind by a count flush. The second is a new change that itself needs a value word. The bench provokes this by sending a value, one repeat, and then two different values back to back. It then expects the count word and both value words on three consecutive cycles, with nothing lost or reordered. A second pairing, a counter fill next to a change, is covered by running the counter to its limit in 8-bit and 16-bit modes and then changing the value. The bench expects only a value word, because the count has restarted at zero.

// File: rtl/rle_cap_pkg.sv
package rle_cap_pkg;
  localparam int WORD_W = 32;
  localparam int MODE_W = 2;
  localparam int MIN_W  = 8;

  // Stored word width selected by the channel mode, clamped to WORD_W.
  function automatic int mode_width(input logic [MODE_W-1:0] m);
    int w;
    w = MIN_W << m;
    if (w > WORD_W) w = WORD_W;
    return w;
  endfunction

  // Ones across the channel/count field (word width minus the flag).
  function automatic logic [WORD_W-1:0] field_mask(input logic [MODE_W-1:0] m);
    return {WORD_W{1'b1}} >> (WORD_W - mode_width(m) + 1);
  endfunction

  // Single bit at the flag position.
  function automatic logic [WORD_W-1:0] flag_mask(input logic [MODE_W-1:0] m);
    return {{(WORD_W-1){1'b0}}, 1'b1} << (mode_width(m) - 1);
  endfunction

  // Count word: flag set, repeat count in the field.
  function automatic logic [WORD_W-1:0] count_word(input logic [MODE_W-1:0] m,
                                                   input logic [WORD_W-2:0] cnt);
    return flag_mask(m) | ({1'b0, cnt} & field_mask(m));
  endfunction
endpackage

// File: rtl/rle_chan_mask.sv
module rle_chan_mask
  import rle_cap_pkg::*;
(
  input  logic [MODE_W-1:0] chan_mode,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout,
  output logic [WORD_W-1:0] fmask,
  output logic [WORD_W-1:0] fflag
);
  always_comb begin
    fmask = field_mask(chan_mode);
    fflag = flag_mask(chan_mode);
    dout  = din & fmask;
  end
endmodule

// File: rtl/rle_run_counter.sv
module rle_run_counter #(
  parameter int CNT_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt_q,
  output logic             hit_max
);
  assign hit_max = inc && (cnt_q == limit - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (inc)      cnt_q <= hit_max ? '0 : cnt_q + CNT_W'(1);
  end

  // R6: a fill restarts the count at zero
  p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_max && !clr) |=> (cnt_q == '0));
endmodule

// File: rtl/rle_word_reg.sv
module rle_word_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         wr_en,
  output logic [W-1:0] wr_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_data <= '0;
    end else begin
      wr_en <= load;
      if (load) wr_data <= din;
    end
  end
endmodule

// File: rtl/rle_capture_enc.sv
module rle_capture_enc
  import rle_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_en,
  input  logic [WORD_W-1:0] smp_data,
  input  logic [MODE_W-1:0] chan_mode,
  input  logic              rle_en,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_data
);
  localparam int CNT_W = WORD_W - 1;

  logic [WORD_W-1:0] fmask, fflag, smp_clean;
  logic [WORD_W-1:0] held_q, pend_val_q, word_nxt;
  logic              have_q, pend_q, pend_set, word_vld;
  logic [CNT_W-1:0]  run_cnt;
  logic              cnt_hit, cnt_clr;
  // named internal events
  logic ev_first, ev_change, ev_repeat, ev_roll, ev_flush, ev_drain;

  rle_chan_mask u_mask (
    .chan_mode (chan_mode),
    .din       (smp_data),
    .dout      (smp_clean),
    .fmask     (fmask),
    .fflag     (fflag)
  );

  assign ev_first  = smp_en && rle_en && !have_q;
  assign ev_change = smp_en && rle_en && have_q && (smp_clean != held_q);
  assign ev_repeat = smp_en && rle_en && have_q && (smp_clean == held_q);
  assign ev_roll   = ev_repeat && cnt_hit;
  assign ev_flush  = ev_change && (run_cnt != '0);
  assign ev_drain  = rle_en && pend_q;
  assign cnt_clr   = !rle_en || ev_first || ev_change;

  rle_run_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cnt_clr),
    .inc     (ev_repeat),
    .limit   (fmask[CNT_W-1:0]),
    .cnt_q   (run_cnt),
    .hit_max (cnt_hit)
  );

  // Word selection: a deferred value word has priority; a change arriving
  // with it becomes the next deferred word (count is zero then).
  always_comb begin
    word_vld = 1'b0;
    word_nxt = '0;
    pend_set = 1'b0;
    if (!rle_en) begin
      word_vld = smp_en;
      word_nxt = smp_clean;
    end else if (ev_drain) begin
      word_vld = 1'b1;
      word_nxt = pend_val_q;
      pend_set = ev_change;
    end else if (ev_first) begin
      word_vld = 1'b1;
      word_nxt = smp_clean;
    end else if (ev_flush) begin
      word_vld = 1'b1;
      word_nxt = count_word(chan_mode, run_cnt);
      pend_set = 1'b1;
    end else if (ev_change) begin
      word_vld = 1'b1;
      word_nxt = smp_clean;
    end else if (ev_roll) begin
      word_vld = 1'b1;
      word_nxt = fflag | fmask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_q     <= 1'b0;
      pend_q     <= 1'b0;
      held_q     <= '0;
      pend_val_q <= '0;
    end else if (!rle_en) begin
      have_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (ev_first || ev_change) begin
        held_q <= smp_clean;
        have_q <= 1'b1;
      end
      pend_q <= pend_set;
      if (pend_set) pend_val_q <= smp_clean;
    end
  end

  rle_word_reg #(.W(WORD_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (word_vld),
    .din     (word_nxt),
    .wr_en   (wr_en),
    .wr_data (wr_data)
  );

  // R9: idle with nothing deferred writes nothing
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_en && !pend_q) |=> !wr_en);
  // R2 / R7: nothing above the field except the flag
  p_field_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((wr_data & ~(fmask | fflag)) == '0));
  // R5: flush writes a count word, then a value word
  p_flush_then_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flush |=> (wr_en && ((wr_data & fflag) != '0)) ##1
                 (wr_en && ((wr_data & fflag) == '0)));
  // R6: fill writes an all-ones count word
  p_roll_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_roll |=> (wr_en && (wr_data == $past(fflag | fmask))));
  // R10: a deferred word never meets a flush or a fill
  p_drain_alone_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (!ev_flush && !ev_roll));
  // R8: plain capture writes flag-clear words
  p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && !rle_en) |=> (wr_en && ((wr_data & fflag) == '0)));
  // R4: a repeat below the limit writes nothing
  p_repeat_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_repeat && !cnt_hit && !pend_q) |=> !wr_en);
endmodule

// File: tb/tb_rle_capture_enc.sv
`timescale 1ns/1ps
module tb_rle_capture_enc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_en = 1'b0;
  logic [31:0] smp_data = '0;
  logic [1:0]  chan_mode = 2'd0;
  logic        rle_en = 1'b1;
  logic        wr_en;
  logic [31:0] wr_data;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rle_capture_enc dut (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .smp_data(smp_data),
    .chan_mode(chan_mode), .rle_en(rle_en), .wr_en(wr_en), .wr_data(wr_data)
  );

  typedef struct packed {
    logic        rle;
    logic [1:0]  mode;
    logic        en;
    logic [31:0] din;
    logic        xwr;
    logic [31:0] xdata;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd0, 1'b1, 32'hFFFF_FF05, 1'b1, 32'h0000_0005}, // R3 first, R2 mask
    '{1'b1, 2'd0, 1'b1, 32'h0000_0005, 1'b0, 32'h0},         // R4 repeat
    '{1'b1, 2'd0, 1'b1, 32'h0000_0085, 1'b0, 32'h0},         // R2 bit7 masked
    '{1'b1, 2'd0, 1'b1, 32'h0000_0006, 1'b1, 32'h0000_0082}, // R5 count 2
    '{1'b1, 2'd0, 1'b0, 32'h0,         1'b1, 32'h0000_0006}, // R5 value follows
    '{1'b1, 2'd0, 1'b1, 32'h0000_0009, 1'b1, 32'h0000_0009}, // R3 change, count 0
    '{1'b1, 2'd0, 1'b1, 32'h0000_000A, 1'b1, 32'h0000_000A}, // R3
    '{1'b1, 2'd0, 1'b1, 32'h0000_000A, 1'b0, 32'h0},         // R4
    '{1'b1, 2'd0, 1'b1, 32'h0000_000B, 1'b1, 32'h0000_0081}, // R5 count 1
    '{1'b1, 2'd0, 1'b1, 32'h0000_000C, 1'b1, 32'h0000_000B}, // R10 drain + change
    '{1'b1, 2'd0, 1'b1, 32'h0000_000C, 1'b1, 32'h0000_000C}, // R10 second value
    '{1'b1, 2'd0, 1'b0, 32'h0,         1'b0, 32'h0},         // R9
    '{1'b1, 2'd0, 1'b1, 32'h0000_000D, 1'b1, 32'h0000_0081}, // R5
    '{1'b1, 2'd0, 1'b0, 32'h0,         1'b1, 32'h0000_000D}, // R5
    '{1'b1, 2'd0, 1'b0, 32'h0,         1'b0, 32'h0},         // R9
    '{1'b1, 2'd1, 1'b0, 32'h0,         1'b0, 32'h0},         // R9
    '{1'b1, 2'd1, 1'b1, 32'h1234_8ABC, 1'b1, 32'h0000_0ABC}, // R7 16-bit field
    '{1'b1, 2'd1, 1'b1, 32'h0000_0ABC, 1'b0, 32'h0},         // R4
    '{1'b1, 2'd1, 1'b1, 32'h0000_0ABD, 1'b1, 32'h0000_8001}, // R7 flag bit 15
    '{1'b1, 2'd1, 1'b0, 32'h0,         1'b1, 32'h0000_0ABD}, // R5
    '{1'b1, 2'd2, 1'b0, 32'h0,         1'b0, 32'h0},         // R9
    '{1'b1, 2'd2, 1'b1, 32'hFFFF_FFFF, 1'b1, 32'h7FFF_FFFF}, // R7 32-bit field
    '{1'b1, 2'd2, 1'b1, 32'h7FFF_FFFF, 1'b0, 32'h0},         // R4
    '{1'b1, 2'd2, 1'b1, 32'h0000_0000, 1'b1, 32'h8000_0001}, // R7 flag bit 31
    '{1'b1, 2'd2, 1'b0, 32'h0,         1'b1, 32'h0000_0000}, // R5
    '{1'b0, 2'd0, 1'b1, 32'h0000_00AB, 1'b1, 32'h0000_002B}, // R8 plain
    '{1'b0, 2'd0, 1'b1, 32'h0000_00AB, 1'b1, 32'h0000_002B}, // R8 no compression
    '{1'b0, 2'd0, 1'b0, 32'h0,         1'b0, 32'h0},         // R9
    '{1'b1, 2'd0, 1'b1, 32'h0000_002B, 1'b1, 32'h0000_002B}, // R8 restart empty
    '{1'b1, 2'd0, 1'b0, 32'h0,         1'b0, 32'h0}          // R9
  };

  task automatic check(input string req, input logic xwr, input logic [31:0] xd);
    compared++;
    if (wr_en !== xwr || (xwr && wr_data !== xd)) begin
      mismatched++;
      $display("FAIL %s: got wr_en=%0b data=%h, expected wr_en=%0b data=%h",
               req, wr_en, wr_data, xwr, xd);
    end
  endtask

  // drive after a falling edge, let one rising edge pass, sample at the next fall
  task automatic step(input logic en, input logic [31:0] d);
    smp_en   = en;
    smp_data = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    smp_en = 1'b0;
    rst_n  = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check("R1 during reset", 1'b0, 32'h0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 after reset", 1'b0, 32'h0);
  endtask

  // run the counter to its limit: lim repeats after the first value
  task automatic fill_run(input string req, input logic [31:0] v, input int lim,
                          input logic [31:0] xroll);
    int writes;
    step(1'b1, v);
    check({req, " first value"}, 1'b1, v);
    writes = 0;
    for (int i = 0; i < lim - 1; i++) begin
      step(1'b1, v);
      if (wr_en) writes++;
    end
    compared++;
    if (writes != 0) begin
      mismatched++;
      $display("FAIL R4 silent repeats: got %0d writes, expected 0", writes);
    end
    step(1'b1, v);
    check({req, " fill word"}, 1'b1, xroll);
  endtask

  initial begin
    @(negedge clk);
    do_reset();

    // table walk
    for (int i = 0; i < NV; i++) begin
      rle_en    = VEC[i].rle;
      chan_mode = VEC[i].mode;
      step(VEC[i].en, VEC[i].din);
      check($sformatf("table row %0d (R2-R10)", i), VEC[i].xwr, VEC[i].xdata);
    end

    // R1: reset mid-run drops the held value
    rle_en = 1'b1; chan_mode = 2'd0;
    step(1'b1, 32'h33);
    check("R1 pre", 1'b1, 32'h33);
    step(1'b1, 32'h33);
    do_reset();
    step(1'b1, 32'h33);
    check("R1 held value dropped", 1'b1, 32'h33);

    // R6: 8-bit fill, then restart at zero
    do_reset();
    chan_mode = 2'd0;
    fill_run("R6 8-bit", 32'h11, 127, 32'h0000_00FF);
    step(1'b1, 32'h11);
    check("R6 repeat after fill silent", 1'b0, 32'h0);
    step(1'b1, 32'h22);
    check("R6 count restarted at 1", 1'b1, 32'h0000_0081);
    step(1'b0, 32'h0);
    check("R6 value after flush", 1'b1, 32'h22);

    // R6: 16-bit fill, change at count zero writes only the value
    do_reset();
    chan_mode = 2'd1;
    fill_run("R6 16-bit", 32'h0111, 32767, 32'h0000_FFFF);
    step(1'b1, 32'h0222);
    check("R6 change at count zero", 1'b1, 32'h0222);
    step(1'b0, 32'h0);
    check("R9 idle after change", 1'b0, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got running, expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule